// File: doc/BRIEF.md
# Four-Level Address Translation Walker

This block resolves a 48-bit virtual address into a physical address after a translation miss. It reads page-table entries one at a time from memory, starting from a root table whose base the requester supplies with each request, and moves down up to four table levels. Each level takes a 9-bit slice of the virtual address as its table index. Each table entry is 64 bits wide, so the entry address is the current table base plus eight times that index.

A walk ends in one of three ways. A leaf at the lowest level maps a 4 KB page. An entry at the second or third level with its large-page bit set maps a 2 MB or 1 GB page and ends the walk early. An entry without its present bit ends the walk with a fault. The walker handles one translation at a time. It holds the result, the level at which the walk ended and the combined permission bits until the requester takes them.

Top module: `xlat_walker`

## Requirements
- R1: After reset the walker is idle: `req_ready` is 1, and `mem_req_valid` and `rsp_valid` are 0.
- R2: A request is taken only on a cycle where `req_valid` and `req_ready` are both 1. `req_ready` stays 0 from acceptance until the result is taken, and any request offered in that time has no effect on the walk in progress.
- R3: The entry read at level L (4 down to 1) is at address {base[51:12], idx, 3'b000}. The base is `req_root[51:12]` at level 4 and bits 51:12 of the previous entry below that. idx is virtual address bits 47:39, 38:30, 29:21 and 20:12 for levels 4, 3, 2 and 1.
- R4: At most one memory read is outstanding, and reads follow level order. A read request keeps `mem_req_valid` and `mem_req_addr` stable until `mem_req_ready`, and the next read is issued only after the response to the previous one.
- R5: An entry with bit 0 clear ends the walk with `rsp_fault`=1, `rsp_level` set to that entry's level, and `rsp_paddr`, `rsp_write` and `rsp_user` all 0.
- R6: A present level-3 entry with bit 7 set ends the walk after 2 reads with `rsp_level`=3 (a 1 GB page). In that case `rsp_paddr` = {entry[51:30], va[29:0]}.
- R7: A present level-2 entry with bit 7 set ends the walk after 3 reads with `rsp_level`=2 (a 2 MB page). In that case `rsp_paddr` = {entry[51:21], va[20:0]}.
- R8: Bit 7 has no effect at levels 4 and 1. A present level-1 entry always ends the walk after 4 reads with `rsp_level`=1 (a 4 KB page) and `rsp_paddr` = {entry[51:12], va[11:0]}.
- R9: For a walk without a fault, `rsp_write` is the AND of bit 1 and `rsp_user` is the AND of bit 2 over every entry read in that walk.
- R10: `rsp_valid` and all result fields stay constant until `rsp_ready` is 1. The walker is idle in the cycle after the result is taken.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | 1 | Translation request offered |
| req_ready | output | 1 | Walker idle and able to take a request |
| req_vaddr | input | 48 | Virtual address to translate |
| req_root | input | 52 | Physical base of the top-level table (bits 11:0 ignored) |
| mem_req_valid | output | 1 | Entry read request |
| mem_req_ready | input | 1 | Memory accepts the read request |
| mem_req_addr | output | 52 | Byte address of the entry to read |
| mem_rsp_valid | input | 1 | Entry data returned |
| mem_rsp_data | input | 64 | Entry contents |
| rsp_valid | output | 1 | Translation result available |
| rsp_ready | input | 1 | Requester takes the result |
| rsp_paddr | output | 52 | Translated physical address |
| rsp_level | output | 3 | Level at which the walk ended: 1 = 4 KB, 2 = 2 MB, 3 = 1 GB, or the faulting level |
| rsp_fault | output | 1 | Walk ended on a non-present entry |
| rsp_write | output | 1 | Write permitted |
| rsp_user | output | 1 | User access permitted |

## Verification
The assertions check the following on every cycle:
- the read handshake and the result both stay stable while they wait;
- the stored virtual address does not change during a walk;
- a fault result carries no address or permission;
- the page offset passes through to every successful result;
- the number of reads a walk made matches the level at which it ended.

Only the bench scenarios can show that each entry address is formed from the right index field and base, which physical address is built for each page size, and how permissions combine across levels. They also show that the large-page bit has no effect at levels 4 and 1. The bench sweeps these over several virtual addresses, every ending level and every single-level permission drop, with memory stalls, late result acceptance and requests offered while busy.

// File: rtl/xlat_pkg.sv
package xlat_pkg;

  localparam int ENTRY_BYTES_LOG2 = 3;

  localparam int BIT_PRESENT = 0;
  localparam int BIT_WRITE   = 1;
  localparam int BIT_USER    = 2;
  localparam int BIT_LARGE   = 7;

  typedef enum logic [1:0] {
    ST_IDLE,
    ST_ISSUE,
    ST_WAIT,
    ST_DONE
  } walk_state_t;

  // Width of the page offset for a leaf found at level lvl (1 = base page).
  function automatic int offset_width(input int off_w, input int idx_w, input int lvl);
    return off_w + (lvl - 1) * idx_w;
  endfunction

  // Byte address of an entry inside a table.
  function automatic logic [63:0] entry_byte_addr(input logic [63:0] table_base,
                                                  input logic [15:0] index);
    return table_base + ({48'd0, index} << ENTRY_BYTES_LOG2);
  endfunction

endpackage

// File: rtl/xlat_index_sel.sv
module xlat_index_sel #(
  parameter int VA_W   = 48,
  parameter int LEVELS = 4,
  parameter int IDX_W  = 9,
  parameter int OFF_W  = 12,
  parameter int LVL_W  = 3
) (
  input  logic [VA_W-1:0]  va,
  input  logic [LVL_W-1:0] lvl,
  output logic [IDX_W-1:0] idx
);

  logic [IDX_W-1:0] field [LEVELS];

  for (genvar g = 0; g < LEVELS; g++) begin : g_field
    assign field[g] = va[OFF_W + g*IDX_W +: IDX_W];
  end

  always_comb begin
    idx = '0;
    for (int k = 0; k < LEVELS; k++) begin
      if (int'(lvl) == k + 1) idx = field[k];
    end
  end

endmodule

// File: rtl/xlat_entry_dec.sv
module xlat_entry_dec
  import xlat_pkg::*;
#(
  parameter int ENT_W  = 64,
  parameter int PA_W   = 52,
  parameter int OFF_W  = 12,
  parameter int LEVELS = 4,
  parameter int LVL_W  = 3
) (
  input  logic [ENT_W-1:0]      entry,
  input  logic [LVL_W-1:0]      lvl,
  output logic                  present,
  output logic                  can_write,
  output logic                  user_ok,
  output logic                  is_leaf,
  output logic [PA_W-OFF_W-1:0] next_base
);

  logic large_allowed;
  logic last_level;

  assign present       = entry[BIT_PRESENT];
  assign can_write     = entry[BIT_WRITE];
  assign user_ok       = entry[BIT_USER];
  assign next_base     = entry[PA_W-1:OFF_W];
  assign last_level    = (int'(lvl) == 1);
  assign large_allowed = (int'(lvl) >= 2) && (int'(lvl) <= LEVELS - 1);
  assign is_leaf       = present && (last_level || (large_allowed && entry[BIT_LARGE]));

endmodule

// File: rtl/xlat_leaf_addr.sv
module xlat_leaf_addr
  import xlat_pkg::*;
#(
  parameter int PA_W   = 52,
  parameter int VA_W   = 48,
  parameter int LEVELS = 4,
  parameter int IDX_W  = 9,
  parameter int OFF_W  = 12,
  parameter int LVL_W  = 3
) (
  input  logic [PA_W-OFF_W-1:0] frame,
  input  logic [VA_W-1:0]       va,
  input  logic [LVL_W-1:0]      lvl,
  output logic [PA_W-1:0]       paddr
);

  localparam int SIZES = LEVELS - 1;

  logic [PA_W-1:0] cand [SIZES];

  // One candidate per page size; larger pages take more offset bits from va.
  for (genvar g = 0; g < SIZES; g++) begin : g_size
    localparam int OW = offset_width(OFF_W, IDX_W, g + 1);
    assign cand[g] = {frame[PA_W-OFF_W-1 : OW-OFF_W], va[OW-1:0]};
  end

  always_comb begin
    paddr = '0;
    for (int k = 0; k < SIZES; k++) begin
      if (int'(lvl) == k + 1) paddr = cand[k];
    end
  end

endmodule

// File: rtl/xlat_walker.sv
module xlat_walker
  import xlat_pkg::*;
#(
  parameter int VA_W   = 48,
  parameter int PA_W   = 52,
  parameter int ENT_W  = 64,
  parameter int LEVELS = 4,
  parameter int IDX_W  = 9,
  parameter int OFF_W  = 12
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            req_valid,
  output logic            req_ready,
  input  logic [VA_W-1:0] req_vaddr,
  input  logic [PA_W-1:0] req_root,
  output logic            mem_req_valid,
  input  logic            mem_req_ready,
  output logic [PA_W-1:0] mem_req_addr,
  input  logic            mem_rsp_valid,
  input  logic [ENT_W-1:0] mem_rsp_data,
  output logic            rsp_valid,
  input  logic            rsp_ready,
  output logic [PA_W-1:0] rsp_paddr,
  output logic [2:0]      rsp_level,
  output logic            rsp_fault,
  output logic            rsp_write,
  output logic            rsp_user
);

  localparam int BASE_W = PA_W - OFF_W;
  localparam int LVL_W  = 3;
  localparam int CNT_W  = $clog2(LEVELS + 1);

  walk_state_t       state_q;
  logic [VA_W-1:0]   va_q;
  logic [BASE_W-1:0] base_q;
  logic [LVL_W-1:0]  lvl_q;
  logic              perm_w_q, perm_u_q;
  logic [CNT_W-1:0]  walk_reads;
  logic [PA_W-1:0]   res_paddr_q;
  logic [LVL_W-1:0]  res_lvl_q;
  logic              res_fault_q, res_w_q, res_u_q;

  // Named internal events
  logic              take_req;
  logic              read_issued;
  logic              entry_arrived;
  logic [IDX_W-1:0]  cur_idx;
  logic              ent_present, ent_write, ent_user, ent_leaf;
  logic [BASE_W-1:0] ent_next_base;
  logic [PA_W-1:0]   leaf_paddr;
  logic [63:0]       entry_addr_wide;

  assign req_ready     = (state_q == ST_IDLE);
  assign mem_req_valid = (state_q == ST_ISSUE);
  assign rsp_valid     = (state_q == ST_DONE);
  assign take_req      = req_valid && req_ready;
  assign read_issued   = mem_req_valid && mem_req_ready;
  assign entry_arrived = (state_q == ST_WAIT) && mem_rsp_valid;

  xlat_index_sel #(
    .VA_W(VA_W), .LEVELS(LEVELS), .IDX_W(IDX_W), .OFF_W(OFF_W), .LVL_W(LVL_W)
  ) u_index (
    .va(va_q), .lvl(lvl_q), .idx(cur_idx)
  );

  assign entry_addr_wide = entry_byte_addr(64'({base_q, {OFF_W{1'b0}}}), 16'(cur_idx));
  assign mem_req_addr    = entry_addr_wide[PA_W-1:0];

  xlat_entry_dec #(
    .ENT_W(ENT_W), .PA_W(PA_W), .OFF_W(OFF_W), .LEVELS(LEVELS), .LVL_W(LVL_W)
  ) u_decode (
    .entry(mem_rsp_data), .lvl(lvl_q), .present(ent_present), .can_write(ent_write),
    .user_ok(ent_user), .is_leaf(ent_leaf), .next_base(ent_next_base)
  );

  xlat_leaf_addr #(
    .PA_W(PA_W), .VA_W(VA_W), .LEVELS(LEVELS), .IDX_W(IDX_W), .OFF_W(OFF_W), .LVL_W(LVL_W)
  ) u_leaf (
    .frame(ent_next_base), .va(va_q), .lvl(lvl_q), .paddr(leaf_paddr)
  );

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state_q     <= ST_IDLE;
      va_q        <= '0;
      base_q      <= '0;
      lvl_q       <= '0;
      perm_w_q    <= 1'b0;
      perm_u_q    <= 1'b0;
      walk_reads  <= '0;
      res_paddr_q <= '0;
      res_lvl_q   <= '0;
      res_fault_q <= 1'b0;
      res_w_q     <= 1'b0;
      res_u_q     <= 1'b0;
    end else begin
      case (state_q)
        ST_IDLE: begin
          if (take_req) begin
            va_q       <= req_vaddr;
            base_q     <= req_root[PA_W-1:OFF_W];
            lvl_q      <= LVL_W'(LEVELS);
            perm_w_q   <= 1'b1;
            perm_u_q   <= 1'b1;
            walk_reads <= '0;
            state_q    <= ST_ISSUE;
          end
        end
        ST_ISSUE: begin
          if (read_issued) begin
            walk_reads <= walk_reads + 1'b1;
            state_q    <= ST_WAIT;
          end
        end
        ST_WAIT: begin
          if (entry_arrived) begin
            if (!ent_present) begin
              res_fault_q <= 1'b1;
              res_lvl_q   <= lvl_q;
              res_paddr_q <= '0;
              res_w_q     <= 1'b0;
              res_u_q     <= 1'b0;
              state_q     <= ST_DONE;
            end else if (ent_leaf) begin
              res_fault_q <= 1'b0;
              res_lvl_q   <= lvl_q;
              res_paddr_q <= leaf_paddr;
              res_w_q     <= perm_w_q & ent_write;
              res_u_q     <= perm_u_q & ent_user;
              state_q     <= ST_DONE;
            end else begin
              base_q   <= ent_next_base;
              lvl_q    <= lvl_q - 1'b1;
              perm_w_q <= perm_w_q & ent_write;
              perm_u_q <= perm_u_q & ent_user;
              state_q  <= ST_ISSUE;
            end
          end
        end
        ST_DONE: begin
          if (rsp_ready) state_q <= ST_IDLE;
        end
        default: state_q <= ST_IDLE;
      endcase
    end
  end

  assign rsp_paddr = res_paddr_q;
  assign rsp_level = res_lvl_q;
  assign rsp_fault = res_fault_q;
  assign rsp_write = res_w_q;
  assign rsp_user  = res_u_q;

  // R2
  walk_va_frozen_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (state_q != ST_IDLE) |=> $stable(va_q));

  // R4
  mem_req_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_req_valid && !mem_req_ready) |=> (mem_req_valid && $stable(mem_req_addr)));

  // R4
  read_bound_chk: assert property (@(posedge clk) disable iff (!rst_n)
    int'(walk_reads) <= LEVELS);

  // R5
  fault_clean_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (rsp_valid && rsp_fault) |-> (rsp_paddr == '0 && !rsp_write && !rsp_user));

  // R6 R7 R8
  end_level_reads_chk: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_valid |-> (int'(walk_reads) == LEVELS + 1 - int'(rsp_level)));

  // R8
  offset_pass_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (rsp_valid && !rsp_fault) |-> (rsp_paddr[OFF_W-1:0] == va_q[OFF_W-1:0]));

  // R10
  rsp_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (rsp_valid && !rsp_ready) |=> (rsp_valid && $stable(rsp_paddr) && $stable(rsp_level)
      && $stable(rsp_fault) && $stable(rsp_write) && $stable(rsp_user)));

endmodule

// File: tb/xlat_walker_test.sv
module xlat_walker_test;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        req_valid = 1'b0;
  logic        req_ready;
  logic [47:0] req_vaddr = '0;
  logic [51:0] req_root = '0;
  logic        mem_req_valid;
  logic        mem_req_ready = 1'b1;
  logic [51:0] mem_req_addr;
  logic        mem_rsp_valid = 1'b0;
  logic [63:0] mem_rsp_data = '0;
  logic        rsp_valid;
  logic        rsp_ready = 1'b0;
  logic [51:0] rsp_paddr;
  logic [2:0]  rsp_level;
  logic        rsp_fault;
  logic        rsp_write;
  logic        rsp_user;

  always #2.5 clk = ~clk;

  xlat_walker uut (
    .clk(clk), .rst_n(rst_n),
    .req_valid(req_valid), .req_ready(req_ready), .req_vaddr(req_vaddr), .req_root(req_root),
    .mem_req_valid(mem_req_valid), .mem_req_ready(mem_req_ready), .mem_req_addr(mem_req_addr),
    .mem_rsp_valid(mem_rsp_valid), .mem_rsp_data(mem_rsp_data),
    .rsp_valid(rsp_valid), .rsp_ready(rsp_ready), .rsp_paddr(rsp_paddr), .rsp_level(rsp_level),
    .rsp_fault(rsp_fault), .rsp_write(rsp_write), .rsp_user(rsp_user)
  );

  int n_checks = 0;
  int n_fail = 0;

  // Per-level entry flags of the memory model, indexed by level 1..4.
  logic [4:0] pres_m, lg_m, wr_m, us_m;

  // Expected walk outcome
  logic [51:0] exp_addr [4];
  int          exp_n;
  logic        exp_fault, exp_w, exp_u;
  int          exp_lvl;
  logic [51:0] exp_paddr;

  task automatic check(input bit ok, input string req, input string what,
                       input logic [63:0] act, input logic [63:0] exp);
    n_checks++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
    end
  endtask

  // Tables at level L live at addresses whose bits 51:48 equal L.
  function automatic logic [63:0] mem_entry(input logic [51:0] a);
    int l;
    logic [3:0] nxt;
    l = int'(a[51:48]);
    nxt = a[51:48] - 4'd1;
    return {12'h000, nxt, a[38:3], 4'h0, lg_m[l], 4'h0, us_m[l], wr_m[l], pres_m[l]};
  endfunction

  task automatic model(input logic [47:0] va, input logic [51:0] root);
    logic [51:0] tbase, a, mask;
    logic [63:0] e;
    logic [8:0]  ix;
    bit done;
    int ow;
    tbase = {root[51:12], 12'h000};
    exp_n = 0; exp_fault = 0; exp_w = 1; exp_u = 1; exp_lvl = 0; exp_paddr = '0; done = 0;
    for (int l = 4; l >= 1; l--) begin
      if (!done) begin
        ix = va[12 + 9*(l-1) +: 9];
        a = tbase + 52'(ix) * 52'd8;
        exp_addr[exp_n] = a;
        exp_n++;
        e = mem_entry(a);
        if (!e[0]) begin
          exp_fault = 1; exp_lvl = l; exp_paddr = '0; exp_w = 0; exp_u = 0; done = 1;
        end else begin
          exp_w = exp_w & e[1];
          exp_u = exp_u & e[2];
          if (l == 1 || (e[7] && (l == 2 || l == 3))) begin
            ow = 12 + 9*(l-1);
            mask = (52'd1 << ow) - 52'd1;
            exp_paddr = (e[51:0] & ~mask) | ({4'h0, va} & mask);
            exp_lvl = l; done = 1;
          end else begin
            tbase = e[51:0] & ~52'hFFF;
          end
        end
      end
    end
  endtask

  function automatic string end_req(input bit f, input int l);
    if (f) return "R5";
    if (l == 3) return "R6";
    if (l == 2) return "R7";
    return "R8";
  endfunction

  task automatic run_walk(input logic [47:0] va, input logic [51:0] root,
                          input bit stall, input bit hold, input bit poke);
    int n, guard;
    bit got;
    logic [51:0] a;
    string rq;
    logic [51:0] p0;
    model(va, root);
    rq = end_req(exp_fault, exp_lvl);
    @(negedge clk);
    req_vaddr = va; req_root = root; req_valid = 1'b1;
    @(negedge clk);
    if (poke) begin
      req_vaddr = ~va;
      check(req_ready == 1'b0, "R2", "ready while busy", 64'(req_ready), 64'd0);
    end else begin
      req_valid = 1'b0;
    end
    n = 0; guard = 0; got = 0;
    while (!got && guard < 60) begin
      guard++;
      if (rsp_valid) begin
        got = 1;
      end else if (mem_req_valid) begin
        a = mem_req_addr;
        if (n < 4) check(a == exp_addr[n], "R3", "entry address", 64'(a), 64'(exp_addr[n]));
        if (stall && n == 0) begin
          mem_req_ready = 1'b0;
          @(negedge clk);
          check(mem_req_valid && mem_req_addr == a, "R4", "request held while stalled",
                64'(mem_req_addr), 64'(a));
          mem_req_ready = 1'b1;
        end
        @(negedge clk);
        check(mem_req_valid == 1'b0 && rsp_valid == 1'b0, "R4", "second read before response",
              64'(mem_req_valid), 64'd0);
        mem_rsp_valid = 1'b1;
        mem_rsp_data = mem_entry(a);
        @(negedge clk);
        mem_rsp_valid = 1'b0;
        n++;
      end else begin
        @(negedge clk);
      end
    end
    req_valid = 1'b0;
    check(got, rq, "walk completed", 64'(got), 64'd1);
    check(n == exp_n, rq, "read count", 64'(n), 64'(exp_n));
    check(rsp_fault == exp_fault, rq, "fault flag", 64'(rsp_fault), 64'(exp_fault));
    check(int'(rsp_level) == exp_lvl, rq, "end level", 64'(rsp_level), 64'(exp_lvl));
    check(rsp_paddr == exp_paddr, rq, "physical address", 64'(rsp_paddr), 64'(exp_paddr));
    check(rsp_write == exp_w, exp_fault ? "R5" : "R9", "write permission",
          64'(rsp_write), 64'(exp_w));
    check(rsp_user == exp_u, exp_fault ? "R5" : "R9", "user permission",
          64'(rsp_user), 64'(exp_u));
    if (hold) begin
      p0 = rsp_paddr;
      @(negedge clk);
      @(negedge clk);
      check(rsp_valid && rsp_paddr == p0 && int'(rsp_level) == exp_lvl, "R10",
            "result held", 64'(rsp_paddr), 64'(p0));
    end
    rsp_ready = 1'b1;
    @(negedge clk);
    rsp_ready = 1'b0;
    check(!rsp_valid && req_ready, "R10", "idle after accept",
          64'({rsp_valid, req_ready}), 64'b01);
  endtask

  function automatic logic [47:0] va_of(input int i);
    case (i)
      0: return 48'h0000_0000_0000;
      1: return 48'hFFFF_FFFF_FFFF;
      2: return 48'h8040_2010_0ABC;
      3: return 48'h5A5A_C3C3_1234;
      4: return 48'h0000_3FE0_0FFF;
      default: return 48'h7FC0_0001_F000;
    endcase
  endfunction

  initial begin : watchdog
    repeat (150000) @(posedge clk);
    n_checks++;
    n_fail++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
    $finish;
  end

  initial begin : stim
    pres_m = 5'b11110; lg_m = '0; wr_m = 5'b11110; us_m = 5'b11110;
    repeat (3) @(negedge clk);
    // R1
    check(req_ready && !mem_req_valid && !rsp_valid, "R1", "reset state",
          64'({req_ready, mem_req_valid, rsp_valid}), 64'b100);
    rst_n = 1'b1;
    @(negedge clk);
    check(req_ready && !mem_req_valid && !rsp_valid, "R1", "idle after reset",
          64'({req_ready, mem_req_valid, rsp_valid}), 64'b100);
    for (int i = 0; i < 6; i++) begin
      for (int s = 0; s < 8; s++) begin
        for (int p = 0; p < 5; p++) begin
          pres_m = 5'b11110;
          lg_m   = 5'b00000;
          if (s < 4) pres_m[4-s] = 1'b0;
          if (s == 4) lg_m[3] = 1'b1;
          if (s == 5) begin lg_m[2] = 1'b1; lg_m[4] = 1'b1; end
          if (s == 6) begin lg_m[4] = 1'b1; lg_m[1] = 1'b1; end
          wr_m = 5'b11110 & ~(5'd1 << p);
          us_m = 5'b11110 & ~(5'd1 << ((p + 2) % 5));
          run_walk(va_of(i), {4'd4, 24'h000000, 12'(i*37 + s), 12'h000},
                   p == 2, p == 3, p == 1);
        end
      end
    end
    $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
    $finish;
  end

endmodule